// File: doc/BRIEF.md
# Cascadable 32-Source Interrupt Controller

This block gathers 32 interrupt requests into one pending-status word and presents them to a processor on two request lines. One line is for ordinary interrupts and one is for critical interrupts. Software sets up each source through a small register port. A source can be level sensed or edge detected, and it can be active high or active low. Each source can be enabled or masked. Each source is steered to one of the two request lines. Software acknowledges a source by writing a one to its pending bit.

Instances can be chained. A downstream controller feeds one of its request outputs into a source input of an upstream controller. The downstream output stays asserted until its own pending source is cleared, so the upstream controller can treat that input as an ordinary level source. Every source input is assumed to be synchronous to the controller clock.

The register port is a plain single-cycle interface. A write takes effect at the clock edge on which `wr_i` is high. A read strobe latches the addressed word into `rdata_o` at the same edge.

Top module: `intc_cascade32`

## Requirements
- R1: After reset the status, enable (0x2), critical-select (0x3) and trigger (0x5) words read 0, the polarity word (0x4) reads 0xFFFFFFFF, and both request outputs are low.
- R2: In every per-source word, source n sits at bit 31-n, so source 0 is the most significant bit.
- R3: A source whose trigger bit is 0 is level sensed. Its status bit becomes 1 one clock after the input is at its active level: high when its polarity bit is 1, low when it is 0.
- R4: A source whose trigger bit is 1 is edge detected. Its status bit becomes 1 when the input, adjusted for polarity, goes from inactive to active between two clocks. A polarity bit of 1 selects rising edges and 0 selects falling edges. The bit stays set after the input returns to inactive.
- R5: Writing the status word at 0x0 clears each bit written as 1 and leaves each bit written as 0 unchanged.
- R6: Clearing the status bit of a level source whose input is still active has no effect, whether or not the source is enabled.
- R7: If an edge is detected in the same cycle that a write clears that bit, the bit ends up set.
- R8: The masked status word at 0x6 reads status AND enable. Writes to 0x6 are ignored.
- R9: The ordinary request output is the registered OR of the masked status bits whose critical-select bit is 0. The critical request output is the registered OR of the masked status bits whose critical-select bit is 1. Each output follows status, enable and critical-select with one clock of delay.
- R10: A request output stays asserted for as long as its pending source remains uncleared, even after an edge source's input has gone inactive (cascade hold).
- R11: Offsets 0x1, 0x7, 0x8 and every other undefined offset read as 0, and writes to them change no register.
- R12: `rdata_o` is loaded with the addressed word on a clock with `rd_i` high and holds that value on clocks without a read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low reset, synchronous to clk |
| src_i | input | 32 | Interrupt source inputs, indexed by source number |
| addr_i | input | 4 | Register word offset |
| wdata_i | input | 32 | Write data |
| wr_i | input | 1 | Write strobe, one cycle per write |
| rd_i | input | 1 | Read strobe, one cycle per read |
| rdata_o | output | 32 | Registered read data |
| irq_nc_o | output | 1 | Ordinary (non-critical) interrupt request |
| irq_cr_o | output | 1 | Critical interrupt request |

## Verification
The bench sweeps all 32 sources in both level and edge mode.

- **Bit mapping.** A design that mirrored the bit order would report source 0 at bit 0, which the sweep sees as a wrong status word.
- **Acknowledge on a level source.** The bench acknowledges a level source while its input is still held. A design that honoured the clear would drop a request that is still active, and a cascaded upstream controller would lose it.
- **Falling edges and active-low level.** These are exercised by reprogramming the polarity. A design that ignored the polarity bit would either miss these cases or fire on the wrong transition.
- **Set against clear.** The bench lands an edge on the same clock as its acknowledge. A design where the clear wins would lose the interrupt.
- **Steering and read-only words.** The bench moves one source between the two request lines and checks that writes to read-only and unused offsets leave every register intact.

// File: rtl/intc_pkg.sv
package intc_pkg;

    localparam int unsigned ADDR_W = 4;

    localparam logic [ADDR_W-1:0] OFS_STATUS = 4'h0;
    localparam logic [ADDR_W-1:0] OFS_ENABLE = 4'h2;
    localparam logic [ADDR_W-1:0] OFS_CRIT   = 4'h3;
    localparam logic [ADDR_W-1:0] OFS_POL    = 4'h4;
    localparam logic [ADDR_W-1:0] OFS_TRIG   = 4'h5;
    localparam logic [ADDR_W-1:0] OFS_MASKED = 4'h6;

    // Software sees source n at bit (W-1-n); internal vectors are source-indexed.
    function automatic logic [31:0] flip32(input logic [31:0] v);
        logic [31:0] r;
        for (int i = 0; i < 32; i++) begin
            r[i] = v[31-i];
        end
        return r;
    endfunction

endpackage

// File: rtl/intc_srcbank.sv
module intc_srcbank #(
    parameter int unsigned NSRC = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] src_i,
    input  logic [NSRC-1:0] pol_i,
    input  logic [NSRC-1:0] trig_i,
    input  logic [NSRC-1:0] clr_i,
    output logic [NSRC-1:0] stat_o
);

    typedef struct packed {
        logic [NSRC-1:0] stat;
        logic [NSRC-1:0] prev;
    } bank_t;

    bank_t bank_q, bank_d;

    logic [NSRC-1:0] act_d;
    logic [NSRC-1:0] edge_hit_d;
    logic [NSRC-1:0] lvl_hit_d;
    logic [NSRC-1:0] set_d;

    always_comb begin
        act_d      = ~(src_i ^ pol_i);
        edge_hit_d = trig_i & act_d & ~bank_q.prev;
        lvl_hit_d  = ~trig_i & act_d;
        set_d      = edge_hit_d | lvl_hit_d;
        bank_d.prev = act_d;
        bank_d.stat = (bank_q.stat & ~clr_i) | set_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bank_q <= '0;
        end else begin
            bank_q <= bank_d;
        end
    end

    assign stat_o = bank_q.stat;

    AST_LEVEL_STICKS: assert property (@(posedge clk) disable iff (!rst_n)
        (|($past(~trig_i & ~(src_i ^ pol_i))) && $past(rst_n))
        |-> ((bank_q.stat & $past(~trig_i & ~(src_i ^ pol_i)))
             == $past(~trig_i & ~(src_i ^ pol_i))));   // R6

    AST_NO_SPURIOUS_SET: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> ((bank_q.stat & ~$past(bank_q.stat) & ~$past(set_d)) == '0));   // R3

    AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> ((bank_q.stat & $past(clr_i & ~set_d)) == '0));   // R5

endmodule

// File: rtl/intc_regfile.sv
module intc_regfile
    import intc_pkg::*;
#(
    parameter int unsigned NSRC = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [NSRC-1:0]   wdata_i,
    input  logic              wr_i,
    input  logic              rd_i,
    input  logic [NSRC-1:0]   stat_i,
    output logic [NSRC-1:0]   en_o,
    output logic [NSRC-1:0]   crit_o,
    output logic [NSRC-1:0]   pol_o,
    output logic [NSRC-1:0]   trig_o,
    output logic [NSRC-1:0]   clr_o,
    output logic [NSRC-1:0]   rdata_o
);

    typedef struct packed {
        logic [NSRC-1:0] en;
        logic [NSRC-1:0] crit;
        logic [NSRC-1:0] pol;
        logic [NSRC-1:0] trig;
        logic [NSRC-1:0] rdata;
    } cfg_t;

    cfg_t cfg_q, cfg_d;

    logic [NSRC-1:0] wsrc_d;
    logic [NSRC-1:0] rsel_d;

    always_comb begin
        cfg_d  = cfg_q;
        wsrc_d = flip32(wdata_i);
        clr_o  = '0;
        if (wr_i) begin
            unique case (addr_i)
                OFS_STATUS: clr_o      = wsrc_d;
                OFS_ENABLE: cfg_d.en   = wsrc_d;
                OFS_CRIT:   cfg_d.crit = wsrc_d;
                OFS_POL:    cfg_d.pol  = wsrc_d;
                OFS_TRIG:   cfg_d.trig = wsrc_d;
                default:    ;
            endcase
        end
        unique case (addr_i)
            OFS_STATUS: rsel_d = stat_i;
            OFS_ENABLE: rsel_d = cfg_q.en;
            OFS_CRIT:   rsel_d = cfg_q.crit;
            OFS_POL:    rsel_d = cfg_q.pol;
            OFS_TRIG:   rsel_d = cfg_q.trig;
            OFS_MASKED: rsel_d = stat_i & cfg_q.en;
            default:    rsel_d = '0;
        endcase
        if (rd_i) begin
            cfg_d.rdata = flip32(rsel_d);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q.en    <= '0;
            cfg_q.crit  <= '0;
            cfg_q.pol   <= '1;
            cfg_q.trig  <= '0;
            cfg_q.rdata <= '0;
        end else begin
            cfg_q <= cfg_d;
        end
    end

    assign en_o    = cfg_q.en;
    assign crit_o  = cfg_q.crit;
    assign pol_o   = cfg_q.pol;
    assign trig_o  = cfg_q.trig;
    assign rdata_o = cfg_q.rdata;

    AST_MASKED_READONLY: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && addr_i == OFS_MASKED) |=> ($stable(cfg_q.en) && $stable(cfg_q.crit)
                                             && $stable(cfg_q.pol) && $stable(cfg_q.trig)));   // R8

    AST_HOLE_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && (addr_i == 4'h1 || addr_i > OFS_MASKED))
        |=> ($stable(cfg_q.en) && $stable(cfg_q.pol) && $stable(cfg_q.trig)));   // R11

    AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_i |=> $stable(rdata_o));   // R12

endmodule

// File: rtl/intc_outmux.sv
module intc_outmux #(
    parameter int unsigned NSRC = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] stat_i,
    input  logic [NSRC-1:0] en_i,
    input  logic [NSRC-1:0] crit_i,
    output logic            irq_nc_o,
    output logic            irq_cr_o
);

    typedef struct packed {
        logic nc;
        logic cr;
    } req_t;

    req_t req_q, req_d;
    logic [NSRC-1:0] live_d;

    always_comb begin
        live_d = stat_i & en_i;
        req_d.nc = |(live_d & ~crit_i);
        req_d.cr = |(live_d & crit_i);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req_q <= '0;
        end else begin
            req_q <= req_d;
        end
    end

    assign irq_nc_o = req_q.nc;
    assign irq_cr_o = req_q.cr;

    AST_NC_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        irq_nc_o |-> $past(|(stat_i & en_i & ~crit_i)));   // R9

    AST_CR_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        irq_cr_o |-> $past(|(stat_i & en_i & crit_i)));   // R9

    AST_HOLD_WHILE_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(|(stat_i & en_i & ~crit_i))) |-> irq_nc_o);   // R10

endmodule

// File: rtl/intc_cascade32.sv
module intc_cascade32
    import intc_pkg::*;
#(
    parameter int unsigned NSRC = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NSRC-1:0]   src_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [NSRC-1:0]   wdata_i,
    input  logic              wr_i,
    input  logic              rd_i,
    output logic [NSRC-1:0]   rdata_o,
    output logic              irq_nc_o,
    output logic              irq_cr_o
);

    logic [NSRC-1:0] stat_w;
    logic [NSRC-1:0] en_w;
    logic [NSRC-1:0] crit_w;
    logic [NSRC-1:0] pol_w;
    logic [NSRC-1:0] trig_w;
    logic [NSRC-1:0] clr_w;

    intc_regfile #(.NSRC(NSRC)) regs_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .addr_i  (addr_i),
        .wdata_i (wdata_i),
        .wr_i    (wr_i),
        .rd_i    (rd_i),
        .stat_i  (stat_w),
        .en_o    (en_w),
        .crit_o  (crit_w),
        .pol_o   (pol_w),
        .trig_o  (trig_w),
        .clr_o   (clr_w),
        .rdata_o (rdata_o)
    );

    intc_srcbank #(.NSRC(NSRC)) bank_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .src_i  (src_i),
        .pol_i  (pol_w),
        .trig_i (trig_w),
        .clr_i  (clr_w),
        .stat_o (stat_w)
    );

    intc_outmux #(.NSRC(NSRC)) out_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .stat_i   (stat_w),
        .en_i     (en_w),
        .crit_i   (crit_w),
        .irq_nc_o (irq_nc_o),
        .irq_cr_o (irq_cr_o)
    );

    AST_RESET_QUIET: assert property (@(posedge clk)
        !rst_n |=> (!irq_nc_o && !irq_cr_o));   // R1

endmodule

// File: tb/intc_cascade32_tb_top.sv
module intc_cascade32_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] src_i = '0;
    logic [3:0]  addr_i = '0;
    logic [31:0] wdata_i = '0;
    logic        wr_i = 1'b0;
    logic        rd_i = 1'b0;
    logic [31:0] rdata_o;
    logic        irq_nc_o;
    logic        irq_cr_o;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #2 clk = ~clk;

    intc_cascade32 dut_i (
        .clk(clk), .rst_n(rst_n), .src_i(src_i), .addr_i(addr_i),
        .wdata_i(wdata_i), .wr_i(wr_i), .rd_i(rd_i), .rdata_o(rdata_o),
        .irq_nc_o(irq_nc_o), .irq_cr_o(irq_cr_o)
    );

    function automatic logic [31:0] bit_of(input int s);
        return 32'h8000_0000 >> s;
    endfunction

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_tests++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s got=%08h exp=%08h", req, got, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        addr_i = a; wdata_i = d; wr_i = 1'b1;
        @(negedge clk);
        wr_i = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        addr_i = a; rd_i = 1'b1;
        @(negedge clk);
        rd_i = 1'b0;
        d = rdata_o;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog got=%08h exp=%08h", 32'h0, 32'h1);
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        logic [31:0] en_val;
        repeat (3) tick();
        rst_n = 1'b1;
        tick();

        // R1 reset values
        check("R1 out", {30'd0, irq_nc_o, irq_cr_o}, 32'h0);
        rd(4'h0, v); check("R1 status", v, 32'h0);
        rd(4'h2, v); check("R1 enable", v, 32'h0);
        rd(4'h3, v); check("R1 crit", v, 32'h0);
        rd(4'h4, v); check("R1 pol", v, 32'hFFFF_FFFF);
        rd(4'h5, v); check("R1 trig", v, 32'h0);
        rd(4'h6, v); check("R1 masked", v, 32'h0);

        // Level sweep, all sources: R2 R3 R6 R9
        wr(4'h2, 32'hFFFF_FFFF);
        for (int s = 0; s < 32; s++) begin
            src_i = 32'h1 << s;
            tick();
            rd(4'h0, v); check("R2/R3 level set", v, bit_of(s));
            check("R9 nc on", {31'd0, irq_nc_o}, 32'h1);
            check("R9 cr off", {31'd0, irq_cr_o}, 32'h0);
            wr(4'h0, 32'hFFFF_FFFF);
            rd(4'h0, v); check("R6 clear ignored", v, bit_of(s));
            src_i = '0;
            tick();
            wr(4'h0, bit_of(s));
            rd(4'h0, v); check("R5 level cleared", v, 32'h0);
            check("R9 nc off", {31'd0, irq_nc_o}, 32'h0);
        end

        // R6 with source disabled
        wr(4'h2, 32'h0);
        src_i = 32'h2;
        tick();
        wr(4'h0, bit_of(1));
        rd(4'h0, v); check("R6 disabled", v, bit_of(1));
        src_i = '0; tick();
        wr(4'h0, 32'hFFFF_FFFF);

        // Edge sweep: R4 R5
        wr(4'h5, 32'hFFFF_FFFF);
        for (int s = 0; s < 32; s++) begin
            src_i = 32'h1 << s; tick();
            src_i = '0; tick();
            rd(4'h0, v); check("R4 rising held", v, bit_of(s));
            wr(4'h0, ~bit_of(s));
            rd(4'h0, v); check("R5 zero keeps", v, bit_of(s));
            wr(4'h0, bit_of(s));
            rd(4'h0, v); check("R5 one clears", v, 32'h0);
        end

        // Falling edge on source 3 (R4)
        src_i = 32'h8; tick();
        wr(4'h4, ~bit_of(3));
        wr(4'h0, 32'hFFFF_FFFF);
        rd(4'h0, v); check("R4 no edge on pol flip", v, 32'h0);
        src_i = '0; tick();
        rd(4'h0, v); check("R4 falling", v, bit_of(3));
        wr(4'h0, 32'hFFFF_FFFF);
        // Active-low level on source 3 (R3)
        wr(4'h5, ~bit_of(3));
        tick();
        rd(4'h0, v); check("R3 active low", v, bit_of(3));
        src_i = 32'h8; tick();
        wr(4'h0, bit_of(3));
        rd(4'h0, v); check("R3 inactive high", v, 32'h0);
        wr(4'h4, 32'hFFFF_FFFF);
        src_i = '0; tick();
        wr(4'h5, 32'hFFFF_FFFF);
        wr(4'h0, 32'hFFFF_FFFF);
        rd(4'h0, v); check("R4 clean", v, 32'h0);

        // R7 set wins over clear
        src_i = 32'h1 << 7;
        wr(4'h0, bit_of(7));
        rd(4'h0, v); check("R7 set wins", v, bit_of(7));
        src_i = '0; tick();
        wr(4'h0, 32'hFFFF_FFFF);

        // R8 masked status
        en_val = bit_of(2) | bit_of(9);
        wr(4'h2, en_val);
        src_i = (32'h1 << 2) | (32'h1 << 4); tick();
        src_i = '0; tick();
        rd(4'h6, v); check("R8 masked", v, bit_of(2));
        wr(4'h6, 32'hFFFF_FFFF);
        rd(4'h6, v); check("R8 readonly", v, bit_of(2));
        rd(4'h2, v); check("R8 enable intact", v, en_val);
        check("R9 nc", {31'd0, irq_nc_o}, 32'h1);

        // R9 steering
        wr(4'h3, bit_of(2));
        tick();
        check("R9 cr steered", {30'd0, irq_nc_o, irq_cr_o}, 32'h1);
        wr(4'h2, en_val | bit_of(4));
        tick();
        check("R9 both", {30'd0, irq_nc_o, irq_cr_o}, 32'h3);

        // R10 hold until cleared
        repeat (20) tick();
        check("R10 hold", {30'd0, irq_nc_o, irq_cr_o}, 32'h3);
        wr(4'h0, bit_of(2));
        check("R10 one cycle lag", {30'd0, irq_nc_o, irq_cr_o}, 32'h3);
        tick();
        check("R10 cr dropped", {30'd0, irq_nc_o, irq_cr_o}, 32'h2);

        // R11 holes
        wr(4'h1, 32'hFFFF_FFFF);
        wr(4'h7, 32'hFFFF_FFFF);
        wr(4'h8, 32'hFFFF_FFFF);
        rd(4'h1, v); check("R11 0x1", v, 32'h0);
        rd(4'h7, v); check("R11 0x7", v, 32'h0);
        rd(4'h8, v); check("R11 0x8", v, 32'h0);
        rd(4'h2, v); check("R11 enable intact", v, en_val | bit_of(4));
        rd(4'h4, v); check("R11 pol intact", v, 32'hFFFF_FFFF);

        // R12 read data holds
        rd(4'h6, v); check("R12 read", v, bit_of(4));
        addr_i = 4'h4;
        tick(); tick();
        check("R12 hold", rdata_o, bit_of(4));

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule